// File: doc/BRIEF.md
# Selectable Line Code Encoder/Decoder

This block turns a serial bit stream into a line level and back again. A run-time 2-bit selector picks one of four codes: plain level coding, transition-on-zero coding, and the two bi-phase codes. In the bi-phase codes the line flips at every cell edge, and a mid-cell flip carries the data. The transmit half is paced by two strobes from the surrounding clocking logic. The cell strobe presents a data bit and marks the cell edge. The half strobe marks the middle of the cell, where a bi-phase code may add its second flip.

The receive half takes line samples only when the recovered clock asks for them. An early strobe samples the line. It is placed at mid-cell for the level codes and at the first quarter for the bi-phase codes. A late strobe at the three-quarter point completes a bi-phase cell. Each decoded bit appears with a one-cycle valid pulse. Manchester input is read with the level code selected and the early strobe at the quarter point: the first-half level is the bit, and the late strobe is not used. Clock recovery and framing are outside the block. The selector should only change while both directions are quiet.

Top module: `lcode_xcvr`

## Requirements
- R1: With code 0 (level), one cycle after a cell strobe the line equals the presented bit.
- R2: With code 1 (transition on zero), a cell strobe carrying 1 leaves the line unchanged and one carrying 0 inverts it, one cycle later.
- R3: With code 2 or code 3 (bi-phase), every cell strobe inverts the line one cycle later, whatever the bit.
- R4: With code 2, a bit of 1 makes the next half strobe invert the line, and a bit of 0 makes the half strobe do nothing.
- R5: With code 3, a bit of 0 makes the next half strobe invert the line, and a bit of 1 makes the half strobe do nothing.
- R6: The line changes only in the cycle after a strobe. A half strobe has no effect with code 0 or 1.
- R7: With code 0, an early strobe yields a valid bit equal to the sampled level one cycle later, and a late strobe alone yields nothing.
- R8: With code 1, an early strobe yields 1 when the sample equals the previous code-1 sample and 0 otherwise. The previous sample is 0 after reset and is updated only by code-1 early strobes.
- R9: With code 2, the early sample is held and the next late strobe yields 1 if the two samples differ and 0 if they match.
- R10: With code 3, the next late strobe yields 0 if the two samples differ and 1 if they match.
- R11: Manchester cells read with code 0 and the early strobe in the first half decode a high-to-low cell as 1 and a low-to-high cell as 0.
- R12: Synchronous active-high reset drives the line low, clears the valid output and clears the receive history.
- R13: Valid is high for one cycle per decoded bit. With a bi-phase code it never follows an early strobe directly, and a late strobe with no pending early sample is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_sel | input | 2 | Line code: 0 level, 1 transition on zero, 2 bi-phase mark, 3 bi-phase space |
| tx_cell | input | 1 | Cell edge strobe, presents tx_bit |
| tx_bit | input | 1 | Data bit to send |
| tx_half | input | 1 | Mid-cell strobe |
| tx_line | output | 1 | Encoded line level |
| rx_line | input | 1 | Received line level |
| rx_early | input | 1 | First sample strobe of a cell |
| rx_late | input | 1 | Second sample strobe of a bi-phase cell |
| rx_bit | output | 1 | Decoded bit |
| rx_valid | output | 1 | One-cycle pulse marking rx_bit |

## Verification
Every code is driven on the transmit side with mixed runs of ones and zeros. Each bit is followed by an idle cycle and a half strobe, so boundary flips, mid-cell flips and holds can each be seen apart. On the receive side the bi-phase codes get all four sample pairs. This separates the mark and space mappings, which invert each other on the same line pattern. The transition-on-zero decoder gets repeated and changing levels, which expose whether the previous sample is kept. Manchester cells of both polarities, lone late strobes and late strobes under the level code check that only the right strobe produces output.

// File: rtl/lcode_pkg.sv
package lcode_pkg;

    typedef enum logic [1:0] {
        LC_LEVEL = 2'd0,
        LC_TOGZ  = 2'd1,
        LC_BPM   = 2'd2,
        LC_BPS   = 2'd3
    } lc_mode_e;

    typedef struct packed {
        logic first_smp;
        logic armed;
        logic prev_lvl;
    } lc_rx_state_s;

    typedef struct packed {
        logic data;
        logic valid;
    } lc_rx_out_s;

    function automatic logic lc_is_biphase(lc_mode_e m);
        return m[1];
    endfunction

    function automatic logic lc_mid_flip(lc_mode_e m, logic b);
        return (m == LC_BPM) ? b : ~b;
    endfunction

    function automatic logic lc_biphase_bit(lc_mode_e m, logic a, logic b);
        logic differ;
        differ = a ^ b;
        return (m == LC_BPM) ? differ : ~differ;
    endfunction

endpackage

// File: rtl/lcode_tx.sv
module lcode_tx
    import lcode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lc_mode_e mode,
    input  logic     cell_stb,
    input  logic     cell_bit,
    input  logic     half_stb,
    output logic     line
);

    logic mid_pend;
    logic next_line;

    always_comb begin
        next_line = line;
        if (cell_stb) begin
            unique case (mode)
                LC_LEVEL: next_line = cell_bit;
                LC_TOGZ:  next_line = cell_bit ? line : ~line;
                default:  next_line = ~line;
            endcase
        end else if (half_stb && lc_is_biphase(mode) && mid_pend) begin
            next_line = ~line;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line     <= 1'b0;
            mid_pend <= 1'b0;
        end else begin
            line <= next_line;
            if (cell_stb) begin
                mid_pend <= lc_is_biphase(mode) ? lc_mid_flip(mode, cell_bit) : 1'b0;
            end else if (half_stb) begin
                mid_pend <= 1'b0;
            end
        end
    end

    AST_LEVEL_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (rst)
        (cell_stb && mode == LC_LEVEL) |=> (line == $past(cell_bit))); // R1
    AST_TOGZ_ONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cell_stb && mode == LC_TOGZ && cell_bit) |=> $stable(line)); // R2
    AST_TOGZ_ZERO_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (cell_stb && mode == LC_TOGZ && !cell_bit) |=> (line != $past(line))); // R2
    AST_BIPHASE_EDGE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (cell_stb && lc_is_biphase(mode)) |=> (line != $past(line))); // R3
    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!cell_stb && !half_stb) |=> $stable(line)); // R6
    AST_HALF_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (half_stb && !cell_stb && !lc_is_biphase(mode)) |=> $stable(line)); // R6

endmodule

// File: rtl/lcode_rx.sv
module lcode_rx
    import lcode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lc_mode_e   mode,
    input  logic       line,
    input  logic       early_stb,
    input  logic       late_stb,
    output lc_rx_out_s out
);

    lc_rx_state_s st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            out <= '0;
        end else begin
            out.valid <= 1'b0;
            if (early_stb) begin
                if (lc_is_biphase(mode)) begin
                    st.first_smp <= line;
                    st.armed     <= 1'b1;
                end else begin
                    st.armed  <= 1'b0;
                    out.valid <= 1'b1;
                    if (mode == LC_TOGZ) begin
                        out.data    <= (line == st.prev_lvl);
                        st.prev_lvl <= line;
                    end else begin
                        out.data <= line;
                    end
                end
            end else if (late_stb && st.armed && lc_is_biphase(mode)) begin
                st.armed  <= 1'b0;
                out.valid <= 1'b1;
                out.data  <= lc_biphase_bit(mode, st.first_smp, line);
            end
        end
    end

    AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        out.valid |-> $past(early_stb || late_stb)); // R13
    AST_BIPHASE_EARLY_SILENT: assert property (@(posedge clk) disable iff (rst)
        (early_stb && lc_is_biphase(mode)) |=> !out.valid); // R13
    AST_LEVEL_LATE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (late_stb && !early_stb && !lc_is_biphase(mode)) |=> !out.valid); // R7
    AST_LEVEL_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (early_stb && mode == LC_LEVEL) |=> (out.valid && out.data == $past(line))); // R7

endmodule

// File: rtl/lcode_xcvr.sv
module lcode_xcvr
    import lcode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] code_sel,
    input  logic       tx_cell,
    input  logic       tx_bit,
    input  logic       tx_half,
    output logic       tx_line,
    input  logic       rx_line,
    input  logic       rx_early,
    input  logic       rx_late,
    output logic       rx_bit,
    output logic       rx_valid
);

    lc_mode_e   mode;
    lc_rx_out_s rx_out;

    assign mode = lc_mode_e'(code_sel);

    lcode_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .cell_stb (tx_cell),
        .cell_bit (tx_bit),
        .half_stb (tx_half),
        .line     (tx_line)
    );

    lcode_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .line      (rx_line),
        .early_stb (rx_early),
        .late_stb  (rx_late),
        .out       (rx_out)
    );

    assign rx_bit   = rx_out.data;
    assign rx_valid = rx_out.valid;

    AST_RESET_LINE_LOW: assert property (@(posedge clk)
        rst |=> (!tx_line && !rx_valid)); // R12

endmodule

// File: tb/lcode_xcvr_tb.sv
module lcode_xcvr_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] code_sel = 2'd0;
    logic       tx_cell = 1'b0;
    logic       tx_bit = 1'b0;
    logic       tx_half = 1'b0;
    logic       rx_line = 1'b0;
    logic       rx_early = 1'b0;
    logic       rx_late = 1'b0;
    logic       tx_line;
    logic       rx_bit;
    logic       rx_valid;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    exp_q[$];
    string tag_q[$];
    bit    exp_line = 1'b0;
    bit    rx_prev = 1'b0;

    always #2 clk = ~clk;

    lcode_xcvr u_dut (
        .clk      (clk),
        .rst      (rst),
        .code_sel (code_sel),
        .tx_cell  (tx_cell),
        .tx_bit   (tx_bit),
        .tx_half  (tx_half),
        .tx_line  (tx_line),
        .rx_line  (rx_line),
        .rx_early (rx_early),
        .rx_late  (rx_late),
        .rx_bit   (rx_bit),
        .rx_valid (rx_valid)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: each valid pulse pops one expected bit.
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R13: unexpected valid got 1 expected 0");
            end else begin
                check(tag_q.pop_front(), rx_bit, exp_q.pop_front());
            end
        end
    end

    // Transmit one cell: edge strobe, idle cycle, half strobe.
    task automatic tx_send(input bit b);
        string edge_tag;
        string mid_tag;
        bit    flip;
        case (code_sel)
            2'd0: begin edge_tag = "R1"; mid_tag = "R6"; end
            2'd1: begin edge_tag = "R2"; mid_tag = "R6"; end
            2'd2: begin edge_tag = "R3"; mid_tag = "R4"; end
            default: begin edge_tag = "R3"; mid_tag = "R5"; end
        endcase
        @(negedge clk);
        tx_cell = 1'b1;
        tx_bit  = b;
        @(negedge clk);
        tx_cell = 1'b0;
        if (code_sel == 2'd0)      exp_line = b;
        else if (code_sel == 2'd1) exp_line = b ? exp_line : ~exp_line;
        else                       exp_line = ~exp_line;
        check(edge_tag, tx_line, exp_line);
        @(negedge clk);
        check("R6", tx_line, exp_line);
        tx_half = 1'b1;
        @(negedge clk);
        tx_half = 1'b0;
        flip = (code_sel == 2'd2) ? b : (code_sel == 2'd3) ? ~b : 1'b0;
        if (flip) exp_line = ~exp_line;
        check(mid_tag, tx_line, exp_line);
    endtask

    // Single early sample (level and transition-on-zero codes).
    task automatic rx_single(input bit lvl, input string tag);
        bit e;
        if (code_sel == 2'd1) begin
            e = (lvl == rx_prev);
            rx_prev = lvl;
        end else begin
            e = lvl;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rx_line  = lvl;
        rx_early = 1'b1;
        @(negedge clk);
        rx_early = 1'b0;
        @(negedge clk);
    endtask

    // Two-sample cell; with code 0 the late strobe must be ignored.
    task automatic rx_pair(input bit a, input bit b, input string tag);
        bit e;
        if (code_sel == 2'd2)      e = a ^ b;
        else if (code_sel == 2'd3) e = ~(a ^ b);
        else                       e = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rx_line  = a;
        rx_early = 1'b1;
        @(negedge clk);
        rx_early = 1'b0;
        @(negedge clk);
        rx_line = b;
        rx_late = 1'b1;
        @(negedge clk);
        rx_late = 1'b0;
        @(negedge clk);
    endtask

    task automatic lone_late(input string tag);
        @(negedge clk);
        rx_late = 1'b1;
        @(negedge clk);
        rx_late = 1'b0;
        check(tag, rx_valid, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12", tx_line, 1'b0);
        check("R12", rx_valid, 1'b0);

        // Level code
        code_sel = 2'd0;
        tx_send(1'b1); tx_send(1'b0); tx_send(1'b1); tx_send(1'b1); tx_send(1'b0);
        rx_single(1'b1, "R7"); rx_single(1'b0, "R7");
        rx_single(1'b0, "R7"); rx_single(1'b1, "R7");
        lone_late("R7");
        // Manchester through the level code
        rx_pair(1'b1, 1'b0, "R11");
        rx_pair(1'b0, 1'b1, "R11");
        rx_pair(1'b1, 1'b0, "R11");

        // Transition-on-zero code
        code_sel = 2'd1;
        tx_send(1'b1); tx_send(1'b1); tx_send(1'b0); tx_send(1'b0); tx_send(1'b1); tx_send(1'b0);
        rx_single(1'b1, "R8"); rx_single(1'b1, "R8"); rx_single(1'b0, "R8");
        rx_single(1'b0, "R8"); rx_single(1'b0, "R8"); rx_single(1'b1, "R8");

        // Bi-phase mark
        code_sel = 2'd2;
        tx_send(1'b1); tx_send(1'b0); tx_send(1'b0); tx_send(1'b1);
        rx_pair(1'b0, 1'b1, "R9"); rx_pair(1'b1, 1'b1, "R9");
        rx_pair(1'b1, 1'b0, "R9"); rx_pair(1'b0, 1'b0, "R9");
        lone_late("R13");

        // Bi-phase space
        code_sel = 2'd3;
        tx_send(1'b0); tx_send(1'b1); tx_send(1'b1); tx_send(1'b0);
        rx_pair(1'b0, 1'b1, "R10"); rx_pair(1'b1, 1'b1, "R10");
        rx_pair(1'b1, 1'b0, "R10"); rx_pair(1'b0, 1'b0, "R10");
        lone_late("R13");

        repeat (4) @(negedge clk);
        check("R13", exp_q.size() == 0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule